// File: doc/BRIEF.md
# Multichannel DAC Command Controller

This block is the digital front end of a bank of voltage DACs: a set of output channels plus one shared offset DAC. Each of these targets has two 16-bit registers. An input register takes new data from the serial port. A DAC register holds the value that the analog stage converts. Commands arrive as 32-bit frames over a three-wire serial port made up of a serial clock, an active-low select and a data line. The port is oversampled in the system clock domain, and a frame is decoded only when select is released.

A frame can stage a value in one input register, stage it and apply it at once, or clear every register. A separate active-low load pin moves all input registers into their DAC registers in parallel. This lets several staged channels change on the same cycle. The outputs are the DAC register values of all channels, with the offset DAC last.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset, every channel input and DAC register is 0x0000, and both offset registers hold the parameter OFFSET_INIT.
- R2: A frame is shifted in MSB first, one bit per rising serial clock while cs_ni is low. Frame bits [31:29] are the command code, [28:23] the address and [15:0] the data. Bits [22:16] have no effect.
- R3: A frame is executed at the rising edge of cs_ni only if exactly 32 bits were clocked in. A frame of 31 or 33 bits changes no register.
- R4: Command 3'b010 writes the data to the addressed input register and leaves every DAC register unchanged.
- R5: Command 3'b011 writes the data to both the input register and the DAC register of the addressed target.
- R6: Address NUM_CH (32 by default) selects the offset DAC for commands 010 and 011. Addresses 0 to NUM_CH-1 select the channels.
- R7: A write with an address above NUM_CH changes no register.
- R8: Command 3'b100 sets every input and DAC register, the offset DAC included, to 0x0000.
- R9: While the synchronized ldac_ni is low, every DAC register loads from its own input register on each clock. While ldac_ni is high it has no effect.
- R10: Command codes 000, 001, 101, 110 and 111 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; oversamples the serial port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| cs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data, MSB first |
| ldac_ni | input | 1 | Active-low level load of all DAC registers |
| dac_o | output | (NUM_CH+1)*16 | DAC register values; index NUM_CH is the offset DAC |

## Verification
An input register cannot be seen at the ports. The cases where a register must stay untouched are the hard ones: ignored addresses, unknown codes and malformed frames. They are observed by pulsing ldac_ni after the stimulus, which exposes every input register through the DAC outputs, and comparing the result against a bench model. A second subtle case is a staging write made while ldac_ni is already held low. The bench keeps the pin low across a whole frame and expects the new value to show up on the output with no further pulse. Random frames mix legal and illegal addresses, lengths and codes, so staged data builds up across many operations before each load pulse reveals it.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int FRAME_W = 32;
  localparam int CTRL_W  = 3;
  localparam int ADDR_W  = 6;
  localparam int PAD_W   = 7;
  localparam int DATA_W  = 16;

  localparam logic [CTRL_W-1:0] CMD_STAGE = 3'b010;
  localparam logic [CTRL_W-1:0] CMD_APPLY = 3'b011;
  localparam logic [CTRL_W-1:0] CMD_CLEAR = 3'b100;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] addr;
    logic [PAD_W-1:0]  pad;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import dac_cmd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sclk_i,
  input  logic   cs_ni,
  input  logic   sdi_i,
  output logic   frame_vld_o,
  output frame_t frame_o
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_d_q, cs_d_q;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sclk_rise, cs_rise;

  assign sclk_rise = sclk_i & ~sclk_d_q & ~cs_ni;
  assign cs_rise   = cs_ni & ~cs_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q    <= 1'b0;
      cs_d_q      <= 1'b1;
      shift_q     <= '0;
      cnt_q       <= '0;
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      sclk_d_q    <= sclk_i;
      cs_d_q      <= cs_ni;
      frame_vld_o <= cs_rise && (cnt_q == CNT_W'(FRAME_W));
      if (cs_rise) frame_o <= frame_t'(shift_q);
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shift_q <= {shift_q[FRAME_W-2:0], sdi_i};
        // saturate so long frames stay rejected
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o);
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX));
  p_idle_cnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && cs_d_q) |=> (cnt_q == '0));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import dac_cmd_pkg::*;
#(
  parameter int                NUM_CH      = 32,
  parameter logic [DATA_W-1:0] OFFSET_INIT = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         frame_vld_i,
  input  frame_t                       frame_i,
  input  logic                         xfer_all_i,
  output logic [NUM_CH:0][DATA_W-1:0]  dac_o
);
  localparam int N_TGT = NUM_CH + 1;

  logic [DATA_W-1:0] inp_q [N_TGT];
  logic [DATA_W-1:0] dac_q [N_TGT];
  logic [NUM_CH:0][DATA_W-1:0] inp_flat;

  logic do_clear, do_stage, do_apply;
  assign do_clear = frame_vld_i && (frame_i.ctrl == CMD_CLEAR);
  assign do_stage = frame_vld_i && ((frame_i.ctrl == CMD_STAGE) || (frame_i.ctrl == CMD_APPLY));
  assign do_apply = frame_vld_i && (frame_i.ctrl == CMD_APPLY);

  for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    localparam logic [DATA_W-1:0] RST_V   = (i == NUM_CH) ? OFFSET_INIT : '0;
    logic hit;
    assign hit = (frame_i.addr == MY_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        inp_q[i] <= RST_V;
        dac_q[i] <= RST_V;
      end else if (do_clear) begin
        inp_q[i] <= '0;
        dac_q[i] <= '0;
      end else begin
        if (do_stage && hit) inp_q[i] <= frame_i.data;
        if (do_apply && hit)  dac_q[i] <= frame_i.data;
        else if (xfer_all_i)  dac_q[i] <= inp_q[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_TGT; i++) begin
      inp_flat[i] = inp_q[i];
      dac_o[i]    = dac_q[i];
    end
  end

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_clear |=> ((dac_o == '0) && (inp_flat == '0)));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_vld_i && !xfer_all_i) |=> $stable(dac_o));
  p_ldac_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_all_i && !frame_vld_i) |=> (dac_o == $past(inp_flat)));
  p_bad_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && (frame_i.ctrl != CMD_CLEAR) && (int'(frame_i.addr) > NUM_CH))
      |=> $stable(inp_flat));
  p_stage_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && (frame_i.ctrl == CMD_STAGE) && !xfer_all_i) |=> $stable(dac_o));
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int                NUM_CH      = 32,
  parameter logic [DATA_W-1:0] OFFSET_INIT = '0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sclk_i,
  input  logic                        cs_ni,
  input  logic                        sdi_i,
  input  logic                        ldac_ni,
  output logic [NUM_CH:0][DATA_W-1:0] dac_o
);
  logic   sclk_s, cs_s, sdi_s, ldac_s;
  logic   frame_vld;
  frame_t frame;

  // select and load idle high, clock and data idle low
  sync2 #(.W(4), .RST_VAL(4'b1100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ldac_ni, cs_ni, sclk_i, sdi_i}),
    .q_o   ({ldac_s, cs_s, sclk_s, sdi_s})
  );

  serial_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_s),
    .cs_ni      (cs_s),
    .sdi_i      (sdi_s),
    .frame_vld_o(frame_vld),
    .frame_o    (frame)
  );

  reg_bank #(.NUM_CH(NUM_CH), .OFFSET_INIT(OFFSET_INIT)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_vld_i(frame_vld),
    .frame_i    (frame),
    .xfer_all_i (~ldac_s),
    .dac_o      (dac_o)
  );
endmodule

// File: tb/tb_dac_cmd_ctrl.sv
module tb_dac_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 32;
  localparam int N_TGT      = NUM_CH + 1;
  localparam logic [15:0] OFF_INIT = 16'h4000;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0, ldac_n = 1'b1;
  logic [NUM_CH:0][15:0] dac;

  int checks = 0, errors = 0;
  logic [15:0] m_inp [N_TGT];
  logic [15:0] m_dac [N_TGT];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_ctrl #(.NUM_CH(NUM_CH), .OFFSET_INIT(OFF_INIT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n),
    .sdi_i(sdi), .ldac_ni(ldac_n), .dac_o(dac)
  );

  function automatic logic [31:0] mk(input logic [2:0] c, input logic [5:0] a, input logic [15:0] d);
    logic [6:0] pad;
    pad = 7'($urandom);
    return {c, a, pad, d};
  endfunction

  // model of one accepted frame
  function automatic void model_frame(input logic [31:0] f);
    logic [2:0] c; int a;
    c = f[31:29]; a = int'(f[28:23]);
    if (c == 3'b100) begin
      for (int i = 0; i < N_TGT; i++) begin m_inp[i] = '0; m_dac[i] = '0; end
    end else if ((c == 3'b010 || c == 3'b011) && a <= NUM_CH) begin
      m_inp[a] = f[15:0];
      if (c == 3'b011) m_dac[a] = f[15:0];
    end
    if (!ldac_n) for (int i = 0; i < N_TGT; i++) m_dac[i] = m_inp[i];
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] f, input int n);
    cs_n = 1'b0;
    idle(HALF);
    for (int k = 0; k < n; k++) begin
      sdi = (k < 32) ? f[31-k] : 1'b0;
      idle(HALF);
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
    end
    idle(HALF);
    cs_n = 1'b1;
    idle(10);
    if (n == 32) model_frame(f);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    idle(4);
    ldac_n = 1'b1;
    idle(6);
    for (int i = 0; i < N_TGT; i++) m_dac[i] = m_inp[i];
  endtask

  task automatic check_all(input string tag);
    int bad;
    bad = -1;
    checks++;
    for (int i = 0; i < N_TGT; i++)
      if (bad < 0 && dac[i] !== m_dac[i]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: target %0d actual %h expected %h", tag, bad, dac[bad], m_dac[bad]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_TGT; i++) begin
      m_inp[i] = (i == NUM_CH) ? OFF_INIT : '0;
      m_dac[i] = m_inp[i];
    end
    idle(3);
    rst_ni = 1'b1;
    idle(5);
    check_all("R1 reset state");
    pulse_ldac();
    check_all("R1 reset input regs");

    // R4 stage does not reach output; R2 pad bits randomized
    send(mk(3'b010, 6'd5, 16'hA5A5), 32);
    check_all("R4 stage only");
    pulse_ldac();
    check_all("R4 staged then loaded (R9)");

    send(mk(3'b011, 6'd0, 16'h1234), 32);
    check_all("R5 apply ch0");
    send(mk(3'b011, 6'd31, 16'hFFFF), 32);
    check_all("R5 apply ch31");
    send(mk(3'b011, 6'd32, 16'h8001), 32);
    check_all("R6 apply offset");
    send(mk(3'b010, 6'd32, 16'h0F0F), 32);
    pulse_ldac();
    check_all("R6 stage offset");

    send(mk(3'b011, 6'd33, 16'hDEAD), 32);
    send(mk(3'b010, 6'd63, 16'hBEEF), 32);
    check_all("R7 bad address outputs");
    pulse_ldac();
    check_all("R7 bad address inputs");

    send(mk(3'b011, 6'd7, 16'h7777), 31);
    send(mk(3'b011, 6'd8, 16'h8888), 33);
    check_all("R3 wrong length outputs");
    pulse_ldac();
    check_all("R3 wrong length inputs");

    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 3 || c == 4) continue;
      send(mk(3'(c), 6'd9, 16'h9999), 32);
    end
    check_all("R10 unknown codes outputs");
    pulse_ldac();
    check_all("R10 unknown codes inputs");

    // R9 held low: staging write propagates without a further pulse
    ldac_n = 1'b0;
    idle(6);
    send(mk(3'b010, 6'd12, 16'hC0DE), 32);
    check_all("R9 load held low");
    ldac_n = 1'b1;
    idle(6);
    send(mk(3'b010, 6'd13, 16'h1313), 32);
    check_all("R9 load high no effect");

    send(mk(3'b100, 6'd0, 16'hFFFF), 32);
    check_all("R8 clear outputs");
    pulse_ldac();
    check_all("R8 clear inputs incl offset");

    void'($urandom(32'h5EED_0001));
    for (int it = 0; it < 60; it++) begin
      int op, n;
      logic [2:0] c;
      logic [5:0] a;
      op = int'($urandom_range(0, 99));
      a  = 6'($urandom_range(0, 40));
      c  = (op < 45) ? 3'b010 : (op < 80) ? 3'b011 : (op < 85) ? 3'b100 : 3'($urandom);
      n  = (op % 11 == 0) ? ((op & 1) ? 33 : 31) : 32;
      send(mk(c, a, 16'($urandom)), n);
      check_all("R2 random frame");
      if (it % 5 == 4) begin
        pulse_ldac();
        check_all("R9 random load");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule